// File: doc/BRIEF.md
# Memory Bit Operation Execution Unit

This unit executes the memory bit instructions of a small 8-bit processor core: clear one bit of a byte, set one bit of a byte, branch on the state of one bit, and the two mask-with-accumulator operations that set or clear several bits at once while reporting whether any of them were already set. The core's front end hands over the opcode, the already computed effective address, the branch destination, the accumulator and the sequential program counter together with a one-cycle `start` strobe. The unit then runs its own bus cycles on a byte-wide memory port and returns the next program counter and, for the mask operations, a new zero flag.

Control is a four-state machine. `S_IDLE` waits for a `start` with a recognised opcode (transition IDLE→READ). `S_READ` drives one read cycle and captures the byte; for read-modify-write classes it moves to `S_WRITE` (READ→WRITE), for branches straight to `S_FINISH` (READ→FINISH). `S_WRITE` drives one write cycle to the same address (WRITE→FINISH). `S_FINISH` raises `done` for one cycle with the results and always returns to idle (FINISH→IDLE). Only the zero flag is ever reported; the negative, overflow and carry flags are not touched by any of these operations.

The memory port is combinational on reads: `mem_rdata` must be valid in the same cycle that `mem_re` is high. Writes take effect at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `bitop_unit`

## Requirements
- R1: The selected bit is opcode bits 6:4, and the single-bit mask is 1 shifted left by that value (bit 7 of the opcode does not take part in the index).
- R2: An opcode whose low nibble is 7 and whose bit 7 is 0 (bit clear) writes back the read byte ANDed with the inverted mask.
- R3: An opcode whose low nibble is 7 and whose bit 7 is 1 (bit set) writes back the read byte ORed with the mask.
- R4: An opcode whose low nibble is F and whose bit 7 is 0 (branch if bit clear) returns the branch target as `pc_next` when the tested bit is 0 and `pc_seq` otherwise, and never writes memory.
- R5: An opcode whose low nibble is F and whose bit 7 is 1 (branch if bit set) returns the branch target when the tested bit is 1 and `pc_seq` otherwise, and never writes memory.
- R6: Opcodes 0x04 and 0x0C (mask set) write memory OR accumulator; opcodes 0x14 and 0x1C (mask clear) write memory AND NOT accumulator.
- R7: For the four mask opcodes `z_wr` is high with `done` and `z_flag` is 1 exactly when accumulator AND the byte read before modification is zero; for all other opcodes `z_wr` stays low.
- R8: The read cycle comes in the cycle after `start` is taken; a write, when present, follows in the next cycle at the same address; `done` pulses for one cycle right after the last memory access, and read and write are never high together.
- R9: A `start` with any other opcode, or any `start` while an operation is in progress, is ignored: no memory access and no `done`.
- R10: During and after reset the unit is idle with `mem_re`, `mem_we`, `done` and `z_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the values on the inputs below |
| opcode | input | 8 | Instruction opcode, selects class and bit |
| op_addr | input | 16 | Effective address of the operand byte |
| br_target | input | 16 | Destination for a taken bit branch |
| acc | input | 8 | Accumulator value for the mask operations |
| pc_seq | input | 16 | Program counter of the following instruction |
| mem_rdata | input | 8 | Read data, valid while `mem_re` is high |
| mem_re | output | 1 | Memory read cycle |
| mem_we | output | 1 | Memory write cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| pc_next | output | 16 | Next program counter, valid with `done` |
| z_wr | output | 1 | Zero flag update strobe, valid with `done` |
| z_flag | output | 1 | New zero flag value, valid with `z_wr` |

## Verification
The hardest situation to reach from the ports is a second `start` arriving while the machine is already in its read or write cycle, because a well-behaved front end never issues one. The stimulus holds `start` high past the accepting edge and swaps in a different legal opcode and address during the read cycle, so any leak into the captured operands shows up as a wrong address, wrong data or an extra cycle. Branch outcomes are driven both ways by first setting or clearing the tested bit with a bit write, so the same byte is read back after modification, and the mask operations are run with accumulator patterns that do and do not overlap the memory byte to make the zero flag take both values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BCLR,
        OP_BSET,
        OP_BRCLR,
        OP_BRSET,
        OP_MSET,
        OP_MCLR
    } bop_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_FINISH
    } seq_e;

    function automatic logic is_rmw(input bop_e k);
        return (k == OP_BCLR) || (k == OP_BSET) || (k == OP_MSET) || (k == OP_MCLR);
    endfunction

    function automatic logic is_mask_op(input bop_e k);
        return (k == OP_MSET) || (k == OP_MCLR);
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int OPW     = 8,
    parameter int DW      = 8,
    parameter int IDX_LSB = 4
) (
    input  logic [OPW-1:0] opcode,
    output bop_e           kind,
    output logic [DW-1:0]  mask
);
    localparam int IDXW = $clog2(DW);

    // R1: bit index lives in opcode[6:4]
    assign mask = DW'(1) << opcode[IDX_LSB +: IDXW];

    always_comb begin
        kind = OP_NONE;
        if (opcode[3:0] == 4'h7) begin
            kind = opcode[OPW-1] ? OP_BSET : OP_BCLR;
        end else if (opcode[3:0] == 4'hF) begin
            kind = opcode[OPW-1] ? OP_BRSET : OP_BRCLR;
        end else begin
            unique case (opcode)
                OPW'(8'h04), OPW'(8'h0C): kind = OP_MSET;
                OPW'(8'h14), OPW'(8'h1C): kind = OP_MCLR;
                default:                  kind = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
    import bitop_pkg::*;
#(
    parameter int DW = 8
) (
    input  bop_e          kind,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wdata,
    output logic          bit_hit,
    output logic          z_val
);
    assign bit_hit = |(rdata & mask);
    assign z_val   = ~|(acc & rdata);

    always_comb begin
        unique case (kind)
            OP_BCLR: wdata = rdata & ~mask;
            OP_BSET: wdata = rdata | mask;
            OP_MSET: wdata = rdata | acc;
            OP_MCLR: wdata = rdata & ~acc;
            default: wdata = rdata;
        endcase
    end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rmw,
    output seq_e state
);
    seq_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (go) state_nx = S_READ;
            S_READ:   state_nx = rmw ? S_WRITE : S_FINISH;
            S_WRITE:  state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic [AW-1:0]  op_addr,
    input  logic [AW-1:0]  br_target,
    input  logic [DW-1:0]  acc,
    input  logic [AW-1:0]  pc_seq,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_re,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           done,
    output logic [AW-1:0]  pc_next,
    output logic           z_wr,
    output logic           z_flag
);
    seq_e          state;
    bop_e          kind_in;
    logic [DW-1:0] mask_in;

    bop_e          kind_q;
    logic [DW-1:0] mask_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] tgt_q;
    logic [DW-1:0] acc_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] rdata_q;
    logic [AW-1:0] pc_res;
    logic          z_res;

    logic [DW-1:0] dp_in;
    logic [DW-1:0] dp_wdata;
    logic          dp_hit;
    logic          dp_z;
    logic          accept;
    logic          take;

    bitop_decode #(.OPW(OPW), .DW(DW), .IDX_LSB(4)) u_dec (
        .opcode (opcode),
        .kind   (kind_in),
        .mask   (mask_in)
    );

    assign accept = start && (kind_in != OP_NONE) && (state == S_IDLE);

    bitop_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (accept),
        .rmw   (is_rmw(kind_q)),
        .state (state)
    );

    assign dp_in = (state == S_READ) ? mem_rdata : rdata_q;

    bitop_datapath #(.DW(DW)) u_dp (
        .kind    (kind_q),
        .mask    (mask_q),
        .acc     (acc_q),
        .rdata   (dp_in),
        .wdata   (dp_wdata),
        .bit_hit (dp_hit),
        .z_val   (dp_z)
    );

    assign take = ((kind_q == OP_BRSET) && dp_hit) || ((kind_q == OP_BRCLR) && !dp_hit);

    // operand capture at acceptance, read capture in S_READ
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= OP_NONE;
            mask_q  <= '0;
            addr_q  <= '0;
            tgt_q   <= '0;
            acc_q   <= '0;
            pc_q    <= '0;
            rdata_q <= '0;
            pc_res  <= '0;
            z_res   <= 1'b0;
        end else begin
            if (accept) begin
                kind_q <= kind_in;
                mask_q <= mask_in;
                addr_q <= op_addr;
                tgt_q  <= br_target;
                acc_q  <= acc;
                pc_q   <= pc_seq;
            end
            if (state == S_READ) begin
                rdata_q <= mem_rdata;
                pc_res  <= take ? tgt_q : pc_q;
                z_res   <= dp_z;
            end
        end
    end

    // output process
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = '0;
        done      = 1'b0;
        z_wr      = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_READ:   mem_re = 1'b1;
            S_WRITE: begin
                mem_we    = 1'b1;
                mem_wdata = dp_wdata;
            end
            S_FINISH: begin
                done = 1'b1;
                z_wr = is_mask_op(kind_q);
            end
            default:  ;
        endcase
    end

    assign pc_next = pc_res;
    assign z_flag  = z_res;

    // assertions
    assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re) && ($past(mem_addr) == mem_addr)));

    assert_done_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_re) || $past(mem_we)));

    assert_rd_wr_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_branch_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we |-> !((kind_q == OP_BRSET) || (kind_q == OP_BRCLR))));

    assert_mask_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !is_mask_op(kind_q)) |-> ($countones(mask_q) == 1));

    assert_z_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        z_wr |-> done);

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_FINISH) |=> $stable(addr_q));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] op_addr = '0;
    logic [15:0] br_target = '0;
    logic [7:0]  acc = '0;
    logic [15:0] pc_seq = '0;
    logic [7:0]  mem_rdata;
    logic        mem_re, mem_we, done, z_wr, z_flag;
    logic [15:0] mem_addr, pc_next;
    logic [7:0]  mem_wdata;

    always #2.5 clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_addr(op_addr), .br_target(br_target), .acc(acc), .pc_seq(pc_seq),
        .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
        .pc_next(pc_next), .z_wr(z_wr), .z_flag(z_flag)
    );

    logic [7:0] ram     [0:255];
    logic [7:0] ref_mem [0:255];

    assign mem_rdata = ram[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;

    typedef struct packed {
        logic        re, we, dn, zwe, z;
        logic [15:0] addr, pc;
        logic [7:0]  wd;
    } rec_t;

    rec_t  q[$];
    string tq[$];
    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic rec_t idle_rec();
        rec_t r;
        r = '0;
        return r;
    endfunction

    // per-cycle comparison against the reference queue
    always @(negedge clk) begin
        rec_t  e;
        string tg;
        cyc++;
        if (q.size() != 0) begin
            e  = q.pop_front();
            tg = tq.pop_front();
        end else begin
            e  = idle_rec();
            tg = "R10";
        end
        chk(mem_re == e.re, tg, "mem_re", mem_re, e.re);
        chk(mem_we == e.we, tg, "mem_we", mem_we, e.we);
        chk(done == e.dn, tg, "done", done, e.dn);
        if (e.re || e.we) chk(mem_addr == e.addr, tg, "mem_addr", mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.wd, tg, "mem_wdata", mem_wdata, e.wd);
        if (e.dn) begin
            chk(pc_next == e.pc, tg, "pc_next", pc_next, e.pc);
            chk(z_wr == e.zwe, tg, "z_wr", z_wr, e.zwe);
            if (e.zwe) chk(z_flag == e.z, tg, "z_flag", z_flag, e.z);
        end else begin
            chk(z_wr == 1'b0, tg, "z_wr idle", z_wr, 0);
        end
    end

    // behavioural reference and driver
    task automatic run_op(input logic [7:0] op, input logic [15:0] ad,
                          input logic [15:0] tg, input logic [7:0] a,
                          input logic [15:0] ps, input bit hold);
        rec_t r;
        logic [7:0] m, bm, nv;
        int   idx;
        bit   bclr, bset, brc, brs, mset, mclr, wr, legal;
        @(posedge clk); #1;
        start = 1'b1; opcode = op; op_addr = ad; br_target = tg; acc = a; pc_seq = ps;
        m    = ref_mem[ad[7:0]];
        idx  = (op >> 4) & 7;
        bm   = 8'(1 << idx);
        bclr = (op[3:0] == 4'h7) && !op[7];
        bset = (op[3:0] == 4'h7) && op[7];
        brc  = (op[3:0] == 4'hF) && !op[7];
        brs  = (op[3:0] == 4'hF) && op[7];
        mset = (op == 8'h04) || (op == 8'h0C);
        mclr = (op == 8'h14) || (op == 8'h1C);
        wr   = bclr || bset || mset || mclr;
        legal = wr || brc || brs;
        q.push_back(idle_rec()); tq.push_back("R10");
        if (!legal) begin
            q.push_back(idle_rec()); tq.push_back("R9");
            q.push_back(idle_rec()); tq.push_back("R9");
        end else begin
            r = '0; r.re = 1'b1; r.addr = ad;
            q.push_back(r); tq.push_back("R8");
            if (wr) begin
                if (bclr)      nv = m & ~bm;
                else if (bset) nv = m | bm;
                else if (mset) nv = m | a;
                else           nv = m & ~a;
                ref_mem[ad[7:0]] = nv;
                r = '0; r.we = 1'b1; r.addr = ad; r.wd = nv;
                q.push_back(r);
                if (bclr)      tq.push_back("R1,R2");
                else if (bset) tq.push_back("R1,R3");
                else           tq.push_back("R6");
            end
            r = '0; r.dn = 1'b1; r.pc = ps;
            if (brc && ((m & bm) == 0)) r.pc = tg;
            if (brs && ((m & bm) != 0)) r.pc = tg;
            r.zwe = mset || mclr;
            r.z   = ((a & m) == 0);
            q.push_back(r);
            if (brc)           tq.push_back("R1,R4");
            else if (brs)      tq.push_back("R1,R5");
            else if (r.zwe)    tq.push_back("R7");
            else               tq.push_back("R8");
        end
        @(posedge clk); #1;
        if (hold) begin
            // R9: start held high with a different legal op during the read cycle
            opcode = 8'hB7; op_addr = ad ^ 16'h0033;
            @(posedge clk); #1;
        end
        start = 1'b0;
        while (q.size() != 0) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]     = 8'((i * 37 + 5) & 8'hFF);
            ref_mem[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        // R10: reset state observed by the per-cycle comparison
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1,R3: set each bit, R1,R2: clear each bit
        for (int b = 0; b < 8; b++) run_op(8'((b << 4) | 8'h87), 16'h1010 + 16'(b), 16'h0, 8'h00, 16'h0300, 1'b0);
        for (int b = 0; b < 8; b++) run_op(8'((b << 4) | 8'h07), 16'h1010 + 16'(b), 16'h0, 8'h00, 16'h0302, 1'b0);

        // R4/R5: branches taken and not taken after forcing the bit
        for (int b = 0; b < 8; b++) begin
            run_op(8'((b << 4) | 8'h07), 16'h2040, 16'h0, 8'h00, 16'h0400, 1'b0);
            run_op(8'((b << 4) | 8'h0F), 16'h2040, 16'h5A00 + 16'(b), 8'h00, 16'h0403, 1'b0);
            run_op(8'((b << 4) | 8'h8F), 16'h2040, 16'h5B00 + 16'(b), 8'h00, 16'h0406, 1'b0);
            run_op(8'((b << 4) | 8'h87), 16'h2040, 16'h0, 8'h00, 16'h0409, 1'b0);
            run_op(8'((b << 4) | 8'h0F), 16'h2040, 16'h5C00 + 16'(b), 8'h00, 16'h040C, 1'b0);
            run_op(8'((b << 4) | 8'h8F), 16'h2040, 16'h5D00 + 16'(b), 8'h00, 16'h040F, 1'b0);
        end

        // R6,R7: mask operations with overlapping and disjoint accumulators
        run_op(8'h14, 16'h0050, 16'h0, 8'hFF, 16'h0500, 1'b0);
        run_op(8'h04, 16'h0050, 16'h0, 8'h3C, 16'h0502, 1'b0);
        run_op(8'h0C, 16'h0050, 16'h0, 8'h30, 16'h0504, 1'b0);
        run_op(8'h1C, 16'h0050, 16'h0, 8'h0C, 16'h0507, 1'b0);
        run_op(8'h14, 16'h0050, 16'h0, 8'h0C, 16'h050A, 1'b0);
        run_op(8'h04, 16'h0051, 16'h0, 8'hA5, 16'h050C, 1'b0);
        run_op(8'h1C, 16'h0052, 16'h0, 8'h00, 16'h050F, 1'b0);

        // R9: unsupported opcodes, then read back the same bytes
        run_op(8'hEA, 16'h0050, 16'h0, 8'hFF, 16'h0600, 1'b0);
        run_op(8'h24, 16'h0051, 16'h0, 8'hFF, 16'h0600, 1'b0);
        run_op(8'h08, 16'h0052, 16'h0, 8'hFF, 16'h0600, 1'b0);
        run_op(8'h04, 16'h0050, 16'h0, 8'h00, 16'h0602, 1'b0);
        run_op(8'h04, 16'h0051, 16'h0, 8'h00, 16'h0604, 1'b0);

        // R9: start held high while busy
        run_op(8'h37, 16'h0077, 16'h0, 8'h00, 16'h0700, 1'b1);
        run_op(8'hCF, 16'h0077, 16'h7777, 8'h00, 16'h0703, 1'b1);
        run_op(8'h3F, 16'h0077, 16'h7788, 8'h00, 16'h0706, 1'b1);

        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule